// File: doc/BRIEF.md
# Two-Level Direct-Indexed IPv4 Route Lookup Engine

This block resolves a 32-bit IPv4 destination address to a forwarding result through a longest-prefix match held in two flat tables in an external memory. The first-level table is indexed by the top bits of the address; in a full-size build that is 24 bits. Every prefix of length 24 or less is expanded into the first-level table. A first-level word either carries the final result or points to a 256-entry block in the second-level table. That block covers the longer prefixes under one 24-bit stem, and the low address byte selects the word inside it. Software fills both tables. The engine only reads them.

Addresses arrive on a valid/ready input stream. The engine accepts one address, then issues one or two reads on a table-memory port. That port uses a request handshake; responses come back after a variable latency. The engine then presents a hit flag, the matched prefix length and a 26-bit next-hop index on a valid/ready output stream. Only one lookup is in flight at a time. `in_ready` is low from acceptance until the result leaves. While `out_valid` is high and `out_ready` is low, the result is held unchanged, so the consumer may apply back-pressure for any number of cycles. The memory side may stall the request with `mem_req_ready` low for any number of cycles. Each accepted request is answered by exactly one `mem_rsp_valid` pulse, no earlier than the following cycle. The first-level index width is a parameter so that a simulation can use a small table.

Top module: `route_lookup_engine`

## Requirements
- R1: After reset, `in_ready` is high and `mem_req_valid` and `out_valid` are low.
- R2: One cycle after an address is accepted, `mem_req_valid` rises with `mem_req_sel` = 0 and `mem_req_addr` equal to the top L1_BITS address bits, zero-extended.
- R3: A first-level word is decoded as bit 31 = pointer flag, bits 30:26 = prefix length, bits 25:0 = next-hop index or block number. A nonzero word whose bit 31 is clear ends the lookup after exactly one read. The result is a hit carrying that length and index.
- R4: When bit 31 of the first-level word is set, the cycle after its response shows a second request with `mem_req_sel` = 1 and `mem_req_addr` = {block number, address bits 7:0}.
- R5: A second-level word is always final. Bits 30:26 give the length and bits 25:0 the next hop, and bit 31 is ignored. Such lookups make exactly two reads.
- R6: A first-level word of all zeros, or a second-level word whose bits 30:0 are zero, gives a miss. The output then has `out_hit` = 0, `out_len` = 0 and `out_nexthop` = 0.
- R7: `in_ready` is low from the cycle after acceptance until the cycle after the output handshake. `in_valid` presented in that window is ignored.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_hit`, `out_len` and `out_nexthop` hold their values.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted with unchanged address and select.
- R10: `out_valid` rises in the cycle after the response that ends the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Destination address offered |
| in_ready | output | 1 | Engine idle and able to accept |
| in_addr | input | 32 | Destination IPv4 address |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_sel | output | 1 | 0 = first-level table, 1 = second-level table |
| mem_req_addr | output | 34 | Word address inside the selected table |
| mem_rsp_valid | input | 1 | One-cycle response strobe |
| mem_rsp_data | input | 32 | Table word returned |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | A route matched |
| out_len | output | 5 | Matched prefix length |
| out_nexthop | output | 26 | Next-hop index |

## Verification
Every result has a fixed place in time relative to its cause. The first read is due the cycle after acceptance, a second read the cycle after the first response, and `out_valid` the cycle after the final response. `in_ready` returns the cycle after the output handshake. The bench keeps a behavioural phase model that advances on the same handshakes it drives. It compares `in_ready`, `mem_req_valid` and `out_valid`, plus the request fields and result fields, at every falling edge. A response that comes one cycle early or late, or a result that drifts under back-pressure, therefore shows up at the exact cycle where it happens. Memory latency of one to three cycles, request stalls and output stalls vary from lookup to lookup.

// File: rtl/rl_pkg.sv
package rl_pkg;
  localparam int ENTRY_W = 32;
  localparam int LEN_W   = 5;
  localparam int IDX_W   = 26;
  localparam int BLK_W   = 8;
  localparam int ADDR_W  = 32;
  localparam int L2_AW   = IDX_W + BLK_W;

  typedef struct packed {
    logic             ptr;
    logic [LEN_W-1:0] len;
    logic [IDX_W-1:0] idx;
  } rl_entry_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ1  = 3'd1,
    S_WAIT1 = 3'd2,
    S_REQ2  = 3'd3,
    S_WAIT2 = 3'd4,
    S_DONE  = 3'd5
  } rl_state_e;
endpackage

// File: rtl/rl_entry_decode.sv
module rl_entry_decode
  import rl_pkg::*;
#(
  parameter int LEVEL = 1
) (
  input  logic [ENTRY_W-1:0] word,
  output logic               is_ptr,
  output logic               is_empty,
  output logic [LEN_W-1:0]   len,
  output logic [IDX_W-1:0]   idx
);
  rl_entry_t fld;
  assign fld    = rl_entry_t'(word);
  assign len    = fld.len;
  assign idx    = fld.idx;
  // only the first level may redirect; the second level is always final
  assign is_ptr = fld.ptr & (LEVEL == 1);

  generate
    if (LEVEL == 1) begin : g_first
      assign is_empty = (word == '0);
    end else begin : g_second
      assign is_empty = ({fld.len, fld.idx} == '0);
    end
  endgenerate
endmodule

// File: rtl/rl_addr_gen.sv
module rl_addr_gen
  import rl_pkg::*;
#(
  parameter int L1_BITS = 24
) (
  input  logic [ADDR_W-1:0] dst,
  input  logic [IDX_W-1:0]  blk,
  output logic [L2_AW-1:0]  l1_addr,
  output logic [L2_AW-1:0]  l2_addr
);
  localparam int SHIFT = ADDR_W - L1_BITS;
  localparam int PAD   = L2_AW - ADDR_W;

  logic [ADDR_W-1:0] top_bits;
  assign top_bits = dst >> SHIFT;
  assign l1_addr  = {{PAD{1'b0}}, top_bits};
  assign l2_addr  = {blk, dst[BLK_W-1:0]};
endmodule

// File: rtl/rl_result_hold.sv
module rl_result_hold
  import rl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             hit_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic [IDX_W-1:0] nh_in,
  output logic             hit_q,
  output logic [LEN_W-1:0] len_q,
  output logic [IDX_W-1:0] nh_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      len_q <= '0;
      nh_q  <= '0;
    end else if (load) begin
      hit_q <= hit_in;
      len_q <= len_in;
      nh_q  <= nh_in;
    end
  end
endmodule

// File: rtl/route_lookup_engine.sv
module route_lookup_engine
  import rl_pkg::*;
#(
  parameter int L1_BITS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ADDR_W-1:0]   in_addr,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_sel,
  output logic [L2_AW-1:0]    mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [ENTRY_W-1:0]  mem_rsp_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_hit,
  output logic [LEN_W-1:0]    out_len,
  output logic [IDX_W-1:0]    out_nexthop
);
  rl_state_e         state_q, state_d;
  logic [ADDR_W-1:0] dst_q;
  logic [IDX_W-1:0]  blk_q;
  logic              blk_load;
  logic              res_load, res_hit;
  logic [LEN_W-1:0]  res_len;
  logic [IDX_W-1:0]  res_nh;

  logic              f_ptr, f_empty, s_ptr, s_empty;
  logic [LEN_W-1:0]  f_len, s_len;
  logic [IDX_W-1:0]  f_idx, s_idx;
  logic [L2_AW-1:0]  l1_addr, l2_addr;

  rl_entry_decode #(.LEVEL(1)) u_dec_first (
    .word(mem_rsp_data), .is_ptr(f_ptr), .is_empty(f_empty),
    .len(f_len), .idx(f_idx)
  );

  rl_entry_decode #(.LEVEL(2)) u_dec_second (
    .word(mem_rsp_data), .is_ptr(s_ptr), .is_empty(s_empty),
    .len(s_len), .idx(s_idx)
  );

  rl_addr_gen #(.L1_BITS(L1_BITS)) u_addr (
    .dst(dst_q), .blk(blk_q), .l1_addr(l1_addr), .l2_addr(l2_addr)
  );

  always_comb begin
    state_d  = state_q;
    blk_load = 1'b0;
    res_load = 1'b0;
    res_hit  = 1'b0;
    res_len  = '0;
    res_nh   = '0;
    unique case (state_q)
      S_IDLE:  if (in_valid) state_d = S_REQ1;
      S_REQ1:  if (mem_req_ready) state_d = S_WAIT1;
      S_WAIT1: begin
        if (mem_rsp_valid) begin
          if (f_empty) begin
            res_load = 1'b1;
            state_d  = S_DONE;
          end else if (f_ptr) begin
            blk_load = 1'b1;
            state_d  = S_REQ2;
          end else begin
            res_load = 1'b1;
            res_hit  = 1'b1;
            res_len  = f_len;
            res_nh   = f_idx;
            state_d  = S_DONE;
          end
        end
      end
      S_REQ2:  if (mem_req_ready) state_d = S_WAIT2;
      S_WAIT2: begin
        if (mem_rsp_valid) begin
          res_load = 1'b1;
          state_d  = S_DONE;
          if (!s_empty && !s_ptr) begin
            res_hit = 1'b1;
            res_len = s_len;
            res_nh  = s_idx;
          end
        end
      end
      S_DONE:  if (out_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dst_q   <= '0;
      blk_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && in_valid) dst_q <= in_addr;
      if (blk_load) blk_q <= f_idx;
    end
  end

  rl_result_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(res_load),
    .hit_in(res_hit), .len_in(res_len), .nh_in(res_nh),
    .hit_q(out_hit), .len_q(out_len), .nh_q(out_nexthop)
  );

  assign in_ready      = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_REQ1) || (state_q == S_REQ2);
  assign mem_req_sel   = (state_q == S_REQ2);
  assign mem_req_addr  = mem_req_sel ? l2_addr : l1_addr;
  assign out_valid     = (state_q == S_DONE);
endmodule

// File: rtl/rl_lookup_checker.sv
module rl_lookup_checker
  import rl_pkg::*;
#(
  parameter int L1_BITS = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [ADDR_W-1:0]  in_addr,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_sel,
  input logic [L2_AW-1:0]   mem_req_addr,
  input logic               mem_rsp_valid,
  input logic [ENTRY_W-1:0] mem_rsp_data,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_hit,
  input logic [LEN_W-1:0]   out_len,
  input logic [IDX_W-1:0]   out_nexthop
);
  localparam int UNUSED_W = L1_BITS;
  logic unused_ok;
  assign unused_ok = ^{in_addr, mem_rsp_data, UNUSED_W[0]};

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !mem_req_valid && !out_valid));

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_phase_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, mem_req_valid, out_valid}));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_sel)));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_hit, out_len, out_nexthop})));

  p_out_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(mem_rsp_valid));

  p_second_after_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_valid) && mem_req_sel) |-> $past(mem_rsp_valid));

  p_miss_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_len == '0 && out_nexthop == '0));
endmodule

bind route_lookup_engine rl_lookup_checker #(.L1_BITS(L1_BITS)) u_chk (.*);

// File: tb/route_lookup_engine_test.sv
module route_lookup_engine_test;
  localparam int L1B = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_addr = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_req_sel;
  logic [33:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        out_valid, out_ready = 1'b0, out_hit;
  logic [4:0]  out_len;
  logic [25:0] out_nexthop;

  route_lookup_engine #(.L1_BITS(L1B)) uut (.*);

  always #10 clk = ~clk;

  bit [31:0] l1 [int];
  bit [31:0] l2 [longint];

  int checks = 0, fails = 0, cyc = 0;
  bit timeout = 0;
  int ph = 0, reads = 0, lat = 0;
  bit lat_sel = 0;
  longint lat_addr = 0;
  int seed = 7;
  bit done_flag = 0;
  bit [31:0] cur = 0;
  bit e_hit; bit [4:0] e_len; bit [25:0] e_nh; int e_reads; longint e_l2a;
  bit drv_in_valid = 0, drv_out_ready = 0;
  bit [31:0] drv_in_addr = 0;
  int mem_stall = 0;

  function automatic int rnd();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 8);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit [31:0] rd1(input longint a);
    return l1.exists(int'(a)) ? l1[int'(a)] : 32'h0;
  endfunction
  function automatic bit [31:0] rd2(input longint a);
    return l2.exists(a) ? l2[a] : 32'h0;
  endfunction

  task automatic ref_lookup(input bit [31:0] d);
    bit [31:0] e, w;
    e = rd1(longint'(d >> (32 - L1B)));
    e_hit = 0; e_len = 0; e_nh = 0; e_reads = 1;
    e_l2a = {e[25:0], d[7:0]};
    if (e == 0) begin
    end else if (e[31]) begin
      e_reads = 2;
      w = rd2(e_l2a);
      if (w[30:0] != 0) begin e_hit = 1; e_len = w[30:26]; e_nh = w[25:0]; end
    end else begin
      e_hit = 1; e_len = e[30:26]; e_nh = e[25:0];
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (cyc > 50000 && !timeout) begin
      timeout = 1; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    if (!rst_n) begin
      // R1 while in reset and just after
    end else begin
      chk(in_ready === (ph == 0), "R7 in_ready", in_ready, ph == 0);
      chk(mem_req_valid === (ph == 1 || ph == 3), "R2/R4/R9 mem_req_valid", mem_req_valid, ph == 1 || ph == 3);
      chk(out_valid === (ph == 5), "R10 out_valid", out_valid, ph == 5);
      if (ph == 1 && mem_req_valid) begin
        chk(mem_req_sel === 1'b0, "R2 sel", mem_req_sel, 0);
        chk(mem_req_addr === 34'(cur >> (32 - L1B)), "R2 addr", mem_req_addr, cur >> (32 - L1B));
      end
      if (ph == 3 && mem_req_valid) begin
        chk(mem_req_sel === 1'b1, "R4 sel", mem_req_sel, 1);
        chk(mem_req_addr === 34'(e_l2a), "R4 addr", mem_req_addr, e_l2a);
      end
      if (ph == 5 && out_valid) begin
        chk(out_hit === e_hit, e_hit ? "R3/R5/R8 hit" : "R6 hit", out_hit, e_hit);
        chk(out_len === e_len, e_hit ? "R3/R5/R8 len" : "R6 len", out_len, e_len);
        chk(out_nexthop === e_nh, e_hit ? "R3/R5/R8 nexthop" : "R6 nexthop", out_nexthop, e_nh);
      end
    end
    // memory model
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = rnd();
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = lat_sel ? rd2(lat_addr) : rd1(lat_addr);
      end
    end
    mem_req_ready = (mem_stall == 0) ? 1'b1 : ((rnd() % 3) == 0);
    in_valid  = drv_in_valid;
    in_addr   = drv_in_addr;
    out_ready = drv_out_ready;
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        lat = 1 + (rnd() % 3);
        lat_sel = mem_req_sel;
        lat_addr = longint'(mem_req_addr);
      end
      case (ph)
        0: if (in_valid) begin ph = 1; cur = in_addr; ref_lookup(in_addr); reads = 0; end
        1: if (mem_req_ready) begin ph = 2; reads++; end
        2: if (mem_rsp_valid) ph = (e_reads == 2) ? 3 : 5;
        3: if (mem_req_ready) begin ph = 4; reads++; end
        4: if (mem_rsp_valid) ph = 5;
        5: if (out_ready) begin
             chk(reads == e_reads, e_reads == 2 ? "R5 read count" : "R3 read count", reads, e_reads);
             ph = 0; done_flag = 1;
           end
        default: ph = 0;
      endcase
    end
  endtask

  task automatic run(input bit [31:0] d, input int ostall, input int mstall);
    int left;
    left = ostall;
    mem_stall = mstall;
    done_flag = 0;
    drv_in_valid = 1; drv_in_addr = d; drv_out_ready = 0;
    do cycle(); while (ph == 0 && !timeout);
    drv_in_addr = ~d;   // still offered while busy: must be ignored (R7)
    while (!done_flag && !timeout) begin
      if (ph == 5 && left > 0) begin drv_out_ready = 0; left--; end
      else drv_out_ready = (ph == 5);
      cycle();
    end
    drv_in_valid = 0; drv_out_ready = 0;
    cycle();
  endtask

  initial begin
    // table contents; first-level index is address bits 31:20
    l1[12'h0A0] = {1'b0, 5'd16, 26'h0000123};
    l1[12'h0A1] = {1'b1, 5'd24, 26'd5};
    l2[{26'd5, 8'h80}] = {1'b0, 5'd25, 26'h003ABCD};
    l2[{26'd5, 8'h81}] = {1'b1, 5'd28, 26'h0000077};
    l1[12'hFFF] = {1'b0, 5'd8, 26'h3FFFFFF};
    l1[12'h000] = {1'b1, 5'd0, 26'h3FFFFFF};
    l2[{26'h3FFFFFF, 8'hFF}] = {1'b0, 5'd31, 26'h0000001};
    l1[12'h0B0] = {1'b0, 5'd0, 26'h0000001};

    repeat (3) cycle();
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    chk(mem_req_valid === 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    rst_n = 1'b1;
    cycle();

    for (int pass = 0; pass < 3 && !timeout; pass++) begin
      run(32'h0A01_2345, pass, pass);      // R3 direct hit
      run(32'h0A1F_0080, pass * 2, pass);  // R4/R5 two reads, hit
      run(32'h0A1F_0081, pass, 0);         // R5 bit 31 of second word ignored
      run(32'h0A1F_0082, 0, pass);         // R6 empty second-level word
      run(32'h0A2C_0001, pass + 1, pass);  // R6 empty first-level word
      run(32'hFFF0_0000, 3, pass);         // R3 largest index
      run(32'h000A_BCFF, pass, 1);         // R4 highest block
      run(32'h0B01_0101, 0, 0);            // R3 zero-length route
    end
    for (int k = 0; k < 20 && !timeout; k++)
      run({4'h0, 4'hA, 4'h1, rnd()[19:8], 8'h80 + 8'(k % 3)}, k % 4, k % 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule